// File: doc/BRIEF.md
# Interrupt Cycle and Return Controller

This block is the control sequencer of a small accumulator machine with a 16-bit data word and a 12-bit address. It runs the fetch and decode steps of every instruction. After the last execute step of each instruction it checks for a device request. If interrupts are enabled and the input flag or the output flag is high, it sets the interrupt-cycle flip-flop. The next three timing steps are then used for a fixed save sequence instead of a fetch. That sequence stores the return address in the save word (address 0), disables interrupts and continues at the word after it (address 1).

The block also decodes a dedicated return-from-interrupt instruction. In its first execute step this instruction points the address register at the save word and enables interrupts. In its second step it reloads the program counter from memory. Because the interrupt check only runs after that second step, a request that is already pending enters the handler again with the restored return address. It cannot land on a half-finished return. Two further decoded words enable and disable interrupts. Every other word is treated as a one-step instruction whose datapath lies outside this block.

Top module: `intr_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears PC, AR, TR, the enable flag `ien` and the interrupt-cycle flag `r_flag`. It also sets the timing vector to step T0 (`tsig` = 5'b00001).
- R2: With `r_flag` low, a plain instruction passes through steps T0, T1, T2, T3 and then returns to T0, so it takes four cycles. Step T0 copies PC into AR. Step T1 loads the instruction from `mem_rdata` and increments PC. The timing vector is always one-hot, and bit k means step Tk.
- R3: `r_flag` is set only at the end of an instruction's last execute step, and only when the enable flag (including any change made by that same instruction) is 1 and `fgi` or `fgo` is 1. It never rises at the end of a T0, T1 or T2 step of a normal instruction.
- R4: Interrupt step RT0 (`r_flag` high, step T0) sets AR to 0 and copies PC into TR.
- R5: Interrupt step RT1 raises `mem_we` for one cycle with `mem_addr` = AR = 0 and `mem_wdata` = TR, and clears PC. `mem_we` is high in no other step.
- R6: Interrupt step RT2 sets PC to 1 and clears `ien` and `r_flag`. The next cycle is a T0 fetch from address 1.
- R7: Word 16'hF020 (return) takes two execute steps, T3 and T4. T3 sets AR to 0 and `ien` to 1. T4 loads PC with the low 12 bits of `mem_rdata` and then returns to T0.
- R8: Word 16'hF080 sets `ien`. If a request is pending, the interrupt is taken straight after it, and the address of the following word is saved.
- R9: Word 16'hF040 clears `ien`. No interrupt follows it, even with both flags high.
- R10: A return executed with a request pending enters the handler again and saves the PC restored by that return.
- R11: `fgo` alone triggers the interrupt in the same way as `fgi` alone.
- R12: With `ien` low, or with both flags low, an instruction ends with `r_flag` low and with PC pointing at the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fgi | input | 1 | Input device flag (request pending) |
| fgo | input | 1 | Output device flag (request pending) |
| mem_rdata | input | 16 | Memory word at `mem_addr`, combinational read |
| mem_we | output | 1 | Memory write strobe, high during RT1 |
| mem_addr | output | 12 | Memory address, equal to AR |
| mem_wdata | output | 16 | Memory write data, equal to TR |
| pc | output | 12 | Program counter |
| ar | output | 12 | Address register |
| tr | output | 16 | Temporary register holding the saved return address |
| ien | output | 1 | Interrupt enable flag |
| r_flag | output | 1 | Interrupt-cycle flip-flop |
| tsig | output | 5 | One-hot timing step, bit k = Tk |

## Verification
Every register changes on the clock edge that ends the step that sets it. AR is therefore checked one cycle after T0, PC after T1, and `r_flag` after the edge that ends T3 of a plain word or T4 of a return. The bench drives inputs and samples outputs on falling edges and counts edges from reset release. For example, a preamble word plus a test word ends at exactly eight edges, or nine when the test word is a return. In the save sequence, `mem_we` is checked in the cycle after RT0 and the memory contents one cycle after that. PC = 1 is checked after the third edge that follows the rise of `r_flag`. While the test word is in T1, T2 and T3, `r_flag` is sampled to confirm that it stays low before the boundary.

// File: rtl/intr_seq_pkg.sv
`timescale 1ns/1ps
package intr_seq_pkg;

  // number of timing steps: T0..T2 fetch/decode, T3 execute, T4 return tail
  localparam int SC_N = 5;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_RET   = 2'd1,
    OP_ENA   = 2'd2,
    OP_DIS   = 2'd3
  } op_e;

endpackage

// File: rtl/isc_decode.sv
`timescale 1ns/1ps
module isc_decode
  import intr_seq_pkg::*;
#(
  parameter int              WORD_W   = 16,
  parameter logic [WORD_W-1:0] RET_CODE = 16'hF020,
  parameter logic [WORD_W-1:0] ENA_CODE = 16'hF080,
  parameter logic [WORD_W-1:0] DIS_CODE = 16'hF040
) (
  input  logic [WORD_W-1:0] ir,
  output op_e               op
);

  always_comb begin
    if (ir == RET_CODE)      op = OP_RET;
    else if (ir == ENA_CODE) op = OP_ENA;
    else if (ir == DIS_CODE) op = OP_DIS;
    else                     op = OP_PLAIN;
  end

endmodule

// File: rtl/isc_timer.sv
`timescale 1ns/1ps
module isc_timer #(
  parameter int SC_N = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  output logic [SC_N-1:0] tsig
);

  localparam int SC_W = (SC_N > 1) ? $clog2(SC_N) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SC_N - 1);

  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk) begin
    if (rst)                             sc_q <= '0;
    else if (clr || (sc_q == SC_LAST))   sc_q <= '0;
    else                                 sc_q <= sc_q + 1'b1;
  end

  for (genvar g = 0; g < SC_N; g++) begin : g_dec
    assign tsig[g] = (sc_q == SC_W'(g));
  end

endmodule

// File: rtl/isc_intr_ctl.sv
`timescale 1ns/1ps
module isc_intr_ctl (
  input  logic clk,
  input  logic rst,
  input  logic boundary,
  input  logic ien_set,
  input  logic ien_clr,
  input  logic seq_done,
  input  logic req,
  output logic ien_q,
  output logic r_q
);

  logic ien_next;

  // enable value as the current instruction leaves it
  always_comb begin
    if (ien_set)      ien_next = 1'b1;
    else if (ien_clr) ien_next = 1'b0;
    else              ien_next = ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
      r_q   <= 1'b0;
    end else begin
      ien_q <= ien_next;
      if (seq_done)                          r_q <= 1'b0;
      else if (boundary && ien_next && req)  r_q <= 1'b1;
    end
  end

endmodule

// File: rtl/isc_regs.sv
`timescale 1ns/1ps
module isc_regs #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 12,
  parameter int SAVE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ar_from_pc,
  input  logic              ar_to_save,
  input  logic              tr_from_pc,
  input  logic              pc_inc,
  input  logic              pc_to_save,
  input  logic              pc_from_mem,
  input  logic              ir_load,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] ar_q,
  output logic [WORD_W-1:0] tr_q,
  output logic [WORD_W-1:0] ir_q
);

  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ar_q <= '0;
      tr_q <= '0;
      ir_q <= '0;
    end else begin
      if (ar_to_save)      ar_q <= SAVE_A;
      else if (ar_from_pc) ar_q <= pc_q;

      if (tr_from_pc) tr_q <= WORD_W'(pc_q);

      if (pc_to_save)       pc_q <= SAVE_A;
      else if (pc_from_mem) pc_q <= mem_rdata[ADDR_W-1:0];
      else if (pc_inc)      pc_q <= pc_q + 1'b1;

      if (ir_load) ir_q <= mem_rdata;
    end
  end

endmodule

// File: rtl/intr_seq_ctrl.sv
`timescale 1ns/1ps
module intr_seq_ctrl
  import intr_seq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 12,
  parameter int SAVE_ADDR = 0,
  parameter logic [WORD_W-1:0] RET_CODE = 16'hF020,
  parameter logic [WORD_W-1:0] ENA_CODE = 16'hF080,
  parameter logic [WORD_W-1:0] DIS_CODE = 16'hF040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fgi,
  input  logic              fgo,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [WORD_W-1:0] tr,
  output logic              ien,
  output logic              r_flag,
  output logic [SC_N-1:0]   tsig
);

  logic [WORD_W-1:0] ir_q;
  op_e op;
  logic step_fetch0, step_fetch1, step_exec, step_tail;
  logic rt0, rt1, rt2;
  logic ret_exec, boundary;

  isc_decode #(
    .WORD_W(WORD_W), .RET_CODE(RET_CODE), .ENA_CODE(ENA_CODE), .DIS_CODE(DIS_CODE)
  ) u_dec (
    .ir(ir_q),
    .op(op)
  );

  // steps seen through the interrupt-cycle flag
  assign step_fetch0 = !r_flag && tsig[0];
  assign step_fetch1 = !r_flag && tsig[1];
  assign step_exec   = !r_flag && tsig[3];
  assign step_tail   = !r_flag && tsig[4];
  assign rt0         = r_flag && tsig[0];
  assign rt1         = r_flag && tsig[1];
  assign rt2         = r_flag && tsig[2];

  assign ret_exec = step_exec && (op == OP_RET);
  assign boundary = (step_exec && (op != OP_RET)) || step_tail;

  isc_timer #(.SC_N(SC_N)) u_tmr (
    .clk (clk),
    .rst (rst),
    .clr (boundary || rt2),
    .tsig(tsig)
  );

  isc_intr_ctl u_ictl (
    .clk     (clk),
    .rst     (rst),
    .boundary(boundary),
    .ien_set (ret_exec || (step_exec && (op == OP_ENA))),
    .ien_clr (rt2 || (step_exec && (op == OP_DIS))),
    .seq_done(rt2),
    .req     (fgi || fgo),
    .ien_q   (ien),
    .r_q     (r_flag)
  );

  isc_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SAVE_ADDR(SAVE_ADDR)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .ar_from_pc (step_fetch0),
    .ar_to_save (rt0 || ret_exec),
    .tr_from_pc (rt0),
    .pc_inc     (step_fetch1 || rt2),
    .pc_to_save (rt1),
    .pc_from_mem(step_tail),
    .ir_load    (step_fetch1),
    .mem_rdata  (mem_rdata),
    .pc_q       (pc),
    .ar_q       (ar),
    .tr_q       (tr),
    .ir_q       (ir_q)
  );

  assign mem_we    = rt1;
  assign mem_addr  = ar;
  assign mem_wdata = tr;

endmodule

// File: rtl/isc_chk.sv
`timescale 1ns/1ps
module isc_chk #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 12,
  parameter int SAVE_ADDR = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              fgi,
  input logic              fgo,
  input logic [ADDR_W-1:0] rd_low,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ar,
  input logic [WORD_W-1:0] tr,
  input logic              ien,
  input logic              r_flag,
  input logic [4:0]        tsig
);

  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
  localparam logic [ADDR_W-1:0] HND_A  = ADDR_W'(SAVE_ADDR + 1);

  // R2
  tsig_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(tsig) == 1);

  // R3
  r_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(r_flag) |-> (tsig[0] && $past(fgi || fgo)));

  // R4
  rt0_save_chk: assert property (@(posedge clk) disable iff (rst)
    (r_flag && tsig[0]) |=> (ar == SAVE_A && tr == WORD_W'($past(pc))));

  // R5
  we_only_rt1_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (r_flag && tsig[1] && mem_addr == SAVE_A));

  // R6
  rt2_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (r_flag && tsig[2]) |=> (!r_flag && !ien && pc == HND_A && tsig[0]));

  // R7
  ret_tail_chk: assert property (@(posedge clk) disable iff (rst)
    tsig[4] |=> (tsig[0] && pc == $past(rd_low)));

endmodule

bind intr_seq_ctrl isc_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SAVE_ADDR(SAVE_ADDR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .fgi     (fgi),
  .fgo     (fgo),
  .rd_low  (mem_rdata[ADDR_W-1:0]),
  .mem_we  (mem_we),
  .mem_addr(mem_addr),
  .pc      (pc),
  .ar      (ar),
  .tr      (tr),
  .ien     (ien),
  .r_flag  (r_flag),
  .tsig    (tsig)
);

// File: tb/intr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module intr_seq_ctrl_tb;

  localparam logic [15:0] W_NOP = 16'h7800;
  localparam logic [15:0] W_RET = 16'hF020;
  localparam logic [15:0] W_ENA = 16'hF080;
  localparam logic [15:0] W_DIS = 16'hF040;

  typedef struct packed {
    logic [15:0] instr;
    logic        pre_en;
    logic        fi;
    logic        fo;
    logic        exp_r;
    logic        exp_ien;
    logic [11:0] exp_pc;
  } vec_t;

  // preamble word at 0 (enable word or plain), test word at 1
  localparam vec_t VECS [9] = '{
    '{W_NOP, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 12'h002}, // R3 input flag
    '{W_NOP, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 12'h002}, // R11 output flag
    '{W_NOP, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h002}, // R12 no flag
    '{W_NOP, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h002}, // R12 disabled
    '{W_ENA, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 12'h002}, // R8 enable + pending
    '{W_DIS, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h002}, // R9 disable
    '{W_RET, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 12'h800}, // R10 return + pending
    '{W_RET, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'h800}, // R7 return, idle
    '{W_RET, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 12'h080}  // R10 return, out flag
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fgi = 1'b0;
  logic        fgo = 1'b0;
  logic [15:0] mem_rdata;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [11:0] pc;
  logic [11:0] ar;
  logic [15:0] tr;
  logic        ien;
  logic        r_flag;
  logic [4:0]  tsig;

  logic [15:0] mem [0:4095];
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  intr_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .fgi(fgi), .fgo(fgo), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc(pc), .ar(ar), .tr(tr), .ien(ien), .r_flag(r_flag), .tsig(tsig)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    fgi = 1'b0;
    fgo = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = W_NOP;
  endtask

  task automatic run_all();
    // reset state and fetch steps
    clear_mem();
    do_reset();
    chk(pc == 12'h0, "R1 pc", 32'(pc), 0);
    chk(ar == 12'h0, "R1 ar", 32'(ar), 0);
    chk(!ien && !r_flag, "R1 flags", {30'd0, ien, r_flag}, 0);
    chk(tsig == 5'b00001, "R1 tsig", 32'(tsig), 1);
    step(1);
    chk(ar == 12'h0 && tsig == 5'b00010, "R2 after T0", {ar, 15'd0, tsig}, 2);
    step(1);
    chk(pc == 12'h1 && tsig == 5'b00100, "R2 after T1", {pc, 15'd0, tsig}, {12'h1, 20'h4});
    step(2);
    chk(tsig == 5'b00001 && !r_flag, "R2 back to T0", 32'(tsig), 1);

    // table of single-instruction scenarios
    foreach (VECS[k]) begin
      clear_mem();
      mem[0] = VECS[k].pre_en ? W_ENA : W_NOP;
      mem[1] = VECS[k].instr;
      do_reset();
      step(4);
      fgi = VECS[k].fi;
      fgo = VECS[k].fo;
      for (int s = 0; s < 3; s++) begin
        step(1);
        chk(!r_flag, "R3 no rise mid-instruction", 32'(r_flag), 0);
      end
      step((VECS[k].instr == W_RET) ? 2 : 1);
      chk(r_flag == VECS[k].exp_r, "R3/R8/R9/R11/R12 r_flag", 32'(r_flag), 32'(VECS[k].exp_r));
      chk(ien == VECS[k].exp_ien, "R7/R8/R9 ien", 32'(ien), 32'(VECS[k].exp_ien));
      chk(pc == VECS[k].exp_pc, "R7/R12 pc", 32'(pc), 32'(VECS[k].exp_pc));
      chk(tsig == 5'b00001, "R2 boundary tsig", 32'(tsig), 1);
      if (VECS[k].exp_r) begin
        step(3);
        chk(mem[0] == {4'h0, VECS[k].exp_pc}, "R8/R10 saved word", 32'(mem[0]),
            32'({4'h0, VECS[k].exp_pc}));
        chk(pc == 12'h1 && !r_flag && !ien, "R6 handler entry", {pc, 18'd0, r_flag, ien},
            {12'h1, 20'd0});
      end
    end

    // full save sequence, step by step
    clear_mem();
    mem[0] = W_ENA;
    do_reset();
    step(4);
    fgi = 1'b1;
    step(4);
    chk(r_flag && tsig == 5'b00001, "R3 r set at boundary", {r_flag, 26'd0, tsig}, {1'b1, 31'd1});
    step(1);
    chk(ar == 12'h0 && tr == 16'h0002, "R4 RT0 result", {ar, 4'd0, tr}, 32'h2);
    chk(mem_we && mem_addr == 12'h0 && mem_wdata == 16'h0002, "R5 write port",
        {mem_we, 3'd0, mem_addr, mem_wdata}, {1'b1, 31'h2});
    step(1);
    chk(pc == 12'h0 && mem[0] == 16'h0002 && !mem_we, "R5 RT1 result", {pc, mem[0]}, 32'h2);
    chk(tsig == 5'b00100 && r_flag, "R5 in RT2", {r_flag, 26'd0, tsig}, {1'b1, 31'h4});
    step(1);
    chk(pc == 12'h1 && !ien && !r_flag && tsig == 5'b00001, "R6 RT2 result",
        {pc, ien, r_flag, 13'd0, 1'b0, tsig}, {12'h1, 20'h1});
    step(1);
    chk(ar == 12'h1, "R6 fetch from handler", 32'(ar), 1);

    // return word alone: two execute steps
    clear_mem();
    mem[0] = W_RET;
    do_reset();
    step(4);
    chk(tsig == 5'b10000 && ar == 12'h0 && ien, "R7 after first execute step",
        {tsig, 14'd0, ien, ar}, {5'b10000, 14'd0, 1'b1, 12'h0});
    step(1);
    chk(tsig == 5'b00001 && pc == 12'h020 && !r_flag, "R7 after second execute step",
        {tsig, 15'd0, pc}, {5'b00001, 15'd0, 12'h020});
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule